// File: doc/BRIEF.md
# Banked Boot-Window Memory Controller

This block sits on the bus of a 16-bit-wide processor with a 20-bit byte address space and decodes the top 32 KB of that space, from 0xF8000 to 0xFFFFF. Everything below that region is passed to main RAM unchanged. Inside the region, a two-bit bank number held in an 8-bit control register picks one of four 32 KB layouts out of a 128 KB bank space. One layout is boot ROM. One is a private read/write RAM. Two share a layout that holds upper boot ROM, two 128-byte paged apertures into a 64 KB video memory, and the two page registers that steer those apertures.

Instruction fetches in the region do not use the bank layouts. They take one of three fixed sources, chosen by the same two control bits. The processor sees boot code, main RAM or zeros.

A data write to any ROM-mapped location latches a non-maskable interrupt and loads a fault code. The interrupt stays up until it is acknowledged. All routing outputs are combinational, so each one answers the request in the cycle it is presented.

Top module: `bootwin_ctrl`

## Requirements
- R1: An access with address bits 19:15 not all ones asserts `main_sel`, drives `main_addr` equal to `cpu_addr` and returns `main_rdata`. An opcode fetch in the window with control bits 3:2 = 10 does the same.
- R2: The bank number is bits 3:2 of the byte written on `ctl_wdata` while `ctl_wr` is high. It takes effect from the next rising edge and is 0 after reset.
- R3: In bank 0, a data read at window offset `o` (the low 15 address bits) asserts `rom_sel` with `rom_addr` = `o` and returns `rom_rdata`.
- R4: In bank 2, reads and writes at offset `o` assert `ram_sel` with `ram_addr` = `o`. `mem_we`, `mem_be` and `mem_wdata` follow the request, and reads return `ram_rdata`.
- R5: In banks 1 and 3, offsets 0x4000 to 0x7FFF read boot ROM with `rom_addr` = `o`.
- R6: In banks 1 and 3, offsets 0x3E00 to 0x3E7F reach aperture A and offsets 0x3F00 to 0x3F7F reach aperture B. Each asserts `vram_sel` with `vram_addr` = (page × 128 + `o`[6:0]) mod 65536, using that aperture's page register, and reads return `vram_rdata`.
- R7: In banks 1 and 3, the word at offset 0x3EFE is page register A and the word at 0x3FFE is page register B, each 10 bits wide and 0 after reset. A write with `cpu_be`[0] = 1 stores `cpu_wdata`[9:0]. A write with `cpu_be`[0] = 0 leaves the register unchanged. A read returns the stored value zero-extended to 16 bits.
- R8: A data write to a ROM-mapped location (bank 0 anywhere, or banks 1 and 3 at 0x4000 and above) raises `nmi` at the next edge and loads `err_code` with 0xAE. `err_code` is 0x31 after reset.
- R9: `nmi` stays high until a cycle with `nmi_ack` high, after which it is low. A ROM write in the same cycle as the acknowledge wins, and `err_code` keeps its value through the acknowledge.
- R10: In banks 1 and 3, any offset below 0x4000 that is neither an aperture nor a page register reads 0x0000 with no select asserted. A write there changes nothing and raises no `nmi`.
- R11: An opcode fetch (`cpu_fetch` with `cpu_rd`) in the window ignores the bank layout. Control bits 3:2 = 00 or 01 read ROM at `rom_addr` = `o`, 10 reads main RAM (R1), and 11 returns 0x0000 with no select asserted.
- R12: Selects and addresses are valid in the cycle of the request, and at most one of `main_sel`, `rom_sel`, `ram_sel` and `vram_sel` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 20 | Byte address of the request |
| cpu_be | input | 2 | Byte-lane enables (bit 0 low byte) |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_fetch | input | 1 | Read is an opcode fetch |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, combinational |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register value (bits 3:2 = bank) |
| nmi_ack | input | 1 | Clears the interrupt |
| nmi | output | 1 | Latched illegal-ROM-write interrupt |
| err_code | output | 8 | Fault code status |
| main_sel | output | 1 | Main RAM select |
| main_addr | output | 20 | Main RAM byte address |
| main_rdata | input | 16 | Main RAM read data |
| rom_sel | output | 1 | Boot ROM read select |
| rom_addr | output | 15 | Boot ROM byte address |
| rom_rdata | input | 16 | Boot ROM read data |
| ram_sel | output | 1 | Private RAM select |
| ram_addr | output | 15 | Private RAM byte address |
| ram_rdata | input | 16 | Private RAM read data |
| vram_sel | output | 1 | Video memory select |
| vram_addr | output | 16 | Video memory byte address |
| vram_rdata | input | 16 | Video memory read data |
| mem_we | output | 1 | Write strobe to the selected memory |
| mem_be | output | 2 | Byte enables to the selected memory |
| mem_wdata | output | 16 | Write data to the selected memory |

## Verification
Routing results (selects, addresses and read data) are due in the same cycle as the request. The sweeps therefore change the address and sample one nanosecond later, with no clock edge involved, over every word offset of all four banks and all four fetch modes.

Register results are due one rising edge after the strobe: the bank number, the page registers, and `nmi` with `err_code`. The bench raises each strobe at a falling edge, drops it at the next falling edge, and samples there. That sample point lies past exactly one rising edge. Write side effects on `mem_we` and `ram_sel` are sampled while the write is still held.

// File: rtl/bootwin_pkg.sv
// Shared constants and types for the boot-window controller.
// Assumes a 32 KB window (15 offset bits) and two 128-byte apertures.
package bootwin_pkg;
    localparam int WIN_W    = 15;
    localparam int APER_W   = 7;
    localparam int NUM_APER = 2;

    localparam logic [WIN_W-1:0] APER_BASE [NUM_APER] = '{15'h3E00, 15'h3F00};
    localparam logic [WIN_W-1:0] PAGE_OFF  [NUM_APER] = '{15'h3EFE, 15'h3FFE};

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MAIN,
        TGT_ROM,
        TGT_RAM,
        TGT_APER,
        TGT_PAGE
    } tgt_e;
endpackage

// File: rtl/bootwin_decode.sv
// Combinational address decoder for the boot window.
// Classifies a request into a target and flags ROM-mapped data locations.
// Assumes fetch is already qualified with a read and without a write.
module bootwin_decode
    import bootwin_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fetch,
    input  logic [1:0]        mode,
    output tgt_e              tgt,
    output logic              idx,
    output logic              rom_area,
    output logic [WIN_W-1:0]  off
);
    logic in_win;

    assign in_win = &addr[ADDR_W-1:WIN_W];
    assign off    = addr[WIN_W-1:0];

    // Pick the target from window membership, fetch qualifier and bank.
    always_comb begin
        tgt      = TGT_NONE;
        idx      = 1'b0;
        rom_area = 1'b0;
        if (!in_win) begin
            tgt = TGT_MAIN;
        end else if (fetch) begin
            case (mode)
                2'd0, 2'd1: tgt = TGT_ROM;
                2'd2:       tgt = TGT_MAIN;
                default:    tgt = TGT_NONE;
            endcase
        end else begin
            case (mode)
                2'd0: begin
                    tgt      = TGT_ROM;
                    rom_area = 1'b1;
                end
                2'd2: tgt = TGT_RAM;
                default: begin
                    if (off[WIN_W-1]) begin
                        tgt      = TGT_ROM;
                        rom_area = 1'b1;
                    end else begin
                        for (int i = 0; i < NUM_APER; i++) begin
                            if (off[WIN_W-1:APER_W] == APER_BASE[i][WIN_W-1:APER_W]) begin
                                tgt = TGT_APER;
                                idx = 1'(i);
                            end
                            if (off[WIN_W-1:1] == PAGE_OFF[i][WIN_W-1:1]) begin
                                tgt = TGT_PAGE;
                                idx = 1'(i);
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bootwin_pagereg.sv
// One aperture page register, cleared by reset and loaded on a qualified write.
// Assumes the caller has already decoded the address and checked the low byte lane.
module bootwin_pagereg #(
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page_q
);
    // Hold the page number, replacing it on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)     page_q <= '0;
        else if (wr_en) page_q <= wdata;
    end
endmodule

// File: rtl/bootwin_fault.sv
// Latches the illegal-ROM-write interrupt and the fault code.
// A new fault takes priority over an acknowledge in the same cycle.
module bootwin_fault #(
    parameter int               ERR_W    = 8,
    parameter logic [ERR_W-1:0] ERR_SET  = 8'hAE,
    parameter logic [ERR_W-1:0] ERR_INIT = 8'h31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rom_wr,
    input  logic             ack,
    output logic             nmi,
    output logic [ERR_W-1:0] err_code
);
    // Set on a ROM write, clear on acknowledge, load the code on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi      <= 1'b0;
            err_code <= ERR_INIT;
        end else if (rom_wr) begin
            nmi      <= 1'b1;
            err_code <= ERR_SET;
        end else if (ack) begin
            nmi      <= 1'b0;
        end
    end
endmodule

// File: rtl/bootwin_ctrl.sv
// Top of the banked boot-window controller.
// Routes CPU requests to main RAM, boot ROM, private RAM or paged video
// memory. It keeps the bank number and the page registers and raises NMI
// on ROM writes. Routing is combinational; only state is registered.
module bootwin_ctrl
    import bootwin_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int PAGE_W = 10,
    parameter int VRAM_W = 16,
    parameter int CTL_W  = 8,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_be,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_fetch,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              nmi_ack,
    output logic              nmi,
    output logic [ERR_W-1:0]  err_code,
    output logic              main_sel,
    output logic [ADDR_W-1:0] main_addr,
    input  logic [DATA_W-1:0] main_rdata,
    output logic              rom_sel,
    output logic [WIN_W-1:0]  rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              ram_sel,
    output logic [WIN_W-1:0]  ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              vram_sel,
    output logic [VRAM_W-1:0] vram_addr,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int CAT_W = PAGE_W + APER_W;

    logic [1:0]        ctl_q;
    tgt_e              tgt;
    logic              idx;
    logic              rom_area;
    logic [WIN_W-1:0]  off;
    logic              fetch_q;
    logic              rd_op;
    logic              access;
    logic [PAGE_W-1:0] page_q [NUM_APER];
    logic [CAT_W-1:0]  vram_cat;
    logic              unused_ctl;

    assign unused_ctl = ^{ctl_wdata[CTL_W-1:4], ctl_wdata[1:0]};
    assign rd_op      = cpu_rd & ~cpu_wr;
    assign access     = cpu_rd | cpu_wr;
    assign fetch_q    = cpu_fetch & rd_op;

    // Capture the bank number from the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= 2'b00;
        else if (ctl_wr) ctl_q <= ctl_wdata[3:2];
    end

    bootwin_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr     (cpu_addr),
        .fetch    (fetch_q),
        .mode     (ctl_q),
        .tgt      (tgt),
        .idx      (idx),
        .rom_area (rom_area),
        .off      (off)
    );

    for (genvar g = 0; g < NUM_APER; g++) begin : g_page
        bootwin_pagereg #(.PAGE_W(PAGE_W)) page_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cpu_wr && cpu_be[0] && tgt == TGT_PAGE && idx == 1'(g)),
            .wdata  (cpu_wdata[PAGE_W-1:0]),
            .page_q (page_q[g])
        );
    end

    bootwin_fault #(.ERR_W(ERR_W)) fault_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_wr   (cpu_wr & rom_area),
        .ack      (nmi_ack),
        .nmi      (nmi),
        .err_code (err_code)
    );

    assign vram_cat  = {page_q[idx], off[APER_W-1:0]};

    assign main_sel  = (tgt == TGT_MAIN) & access;
    assign main_addr = cpu_addr;
    assign rom_sel   = (tgt == TGT_ROM) & rd_op;
    assign rom_addr  = off;
    assign ram_sel   = (tgt == TGT_RAM) & access;
    assign ram_addr  = off;
    assign vram_sel  = (tgt == TGT_APER) & access;
    assign vram_addr = vram_cat[VRAM_W-1:0];
    assign mem_we    = cpu_wr;
    assign mem_be    = cpu_be;
    assign mem_wdata = cpu_wdata;

    // Steer read data from the decoded source.
    always_comb begin
        case (tgt)
            TGT_MAIN: cpu_rdata = main_rdata;
            TGT_ROM:  cpu_rdata = rom_rdata;
            TGT_RAM:  cpu_rdata = ram_rdata;
            TGT_APER: cpu_rdata = vram_rdata;
            TGT_PAGE: cpu_rdata = {{(DATA_W-PAGE_W){1'b0}}, page_q[idx]};
            default:  cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bootwin_ctrl_chk.sv
// Property checker for bootwin_ctrl, attached by bind.
module bootwin_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int PAGE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_fetch,
    input logic              nmi_ack,
    input logic              nmi,
    input logic [7:0]        err_code,
    input logic              main_sel,
    input logic [ADDR_W-1:0] main_addr,
    input logic              rom_sel,
    input logic              ram_sel,
    input logic              vram_sel,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [1:0]        bank_mode,
    input logic [PAGE_W-1:0] page_a,
    input logic [PAGE_W-1:0] page_b
);
    logic in_win;
    assign in_win = &cpu_addr[ADDR_W-1:ADDR_W-5];

    // R8
    nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(cpu_wr && in_win));

    // R8
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> err_code == 8'hAE);

    // R9
    nmi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && !cpu_wr) |=> !nmi);

    // R12
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_sel, rom_sel, ram_sel, vram_sel}));

    // R1
    low_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !in_win) |-> (main_sel && main_addr == cpu_addr));

    // R11
    fetch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_fetch && cpu_rd && !cpu_wr && in_win && bank_mode == 2'b11)
        |-> (cpu_rdata == '0 && !main_sel && !rom_sel && !ram_sel && !vram_sel));

    // R7
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> ($stable(page_a) && $stable(page_b)));
endmodule

bind bootwin_ctrl bootwin_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_fetch (cpu_fetch),
    .nmi_ack   (nmi_ack),
    .nmi       (nmi),
    .err_code  (err_code),
    .main_sel  (main_sel),
    .main_addr (main_addr),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel),
    .vram_sel  (vram_sel),
    .cpu_rdata (cpu_rdata),
    .bank_mode (ctl_q),
    .page_a    (page_q[0]),
    .page_b    (page_q[1])
);

// File: tb/bootwin_ctrl_tb.sv
// Sweep bench for bootwin_ctrl: every word offset of every bank and fetch mode.
module bootwin_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [1:0]  cpu_be = 2'b11;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_fetch = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        nmi_ack = 1'b0;
    logic        nmi;
    logic [7:0]  err_code;
    logic        main_sel, rom_sel, ram_sel, vram_sel, mem_we;
    logic [19:0] main_addr;
    logic [14:0] rom_addr, ram_addr;
    logic [15:0] vram_addr, main_rdata, rom_rdata, ram_rdata, vram_rdata, mem_wdata;
    logic [1:0]  mem_be;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [9:0] m_pa = '0, m_pb = '0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign main_rdata = main_addr[15:0] ^ 16'h1234;
    assign rom_rdata  = {1'b1, rom_addr};
    assign ram_rdata  = {1'b0, ram_addr} ^ 16'h5A5A;
    assign vram_rdata = vram_addr ^ 16'hC3C3;

    bootwin_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_fetch(cpu_fetch),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .nmi_ack(nmi_ack), .nmi(nmi), .err_code(err_code),
        .main_sel(main_sel), .main_addr(main_addr), .main_rdata(main_rdata),
        .rom_sel(rom_sel), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .vram_sel(vram_sel), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %h: actual %h expected %h", req, cpu_addr, act, exp);
        end
    endtask

    function automatic logic [15:0] vaddr(input logic [9:0] p, input logic [14:0] o);
        logic [31:0] t;
        t = 32'(p) * 32'd128 + 32'(o[6:0]);
        return t[15:0];
    endfunction

    // Expected read data from the requirements.
    function automatic logic [15:0] model(input logic [19:0] a, input logic f,
                                          input logic [1:0] m, input logic [9:0] pa,
                                          input logic [9:0] pb);
        logic [14:0] o;
        o = a[14:0];
        if (a[19:15] != 5'h1F) return a[15:0] ^ 16'h1234;                 // R1
        if (f) begin                                                        // R11
            if (m == 2'd3) return 16'h0000;
            if (m == 2'd2) return a[15:0] ^ 16'h1234;
            return {1'b1, o};
        end
        if (m == 2'd0) return {1'b1, o};                                    // R3
        if (m == 2'd2) return {1'b0, o} ^ 16'h5A5A;                         // R4
        if (o[14]) return {1'b1, o};                                        // R5
        if (o >= 15'h3E00 && o <= 15'h3E7F) return vaddr(pa, o) ^ 16'hC3C3; // R6
        if (o >= 15'h3F00 && o <= 15'h3F7F) return vaddr(pb, o) ^ 16'hC3C3;
        if (o[14:1] == 14'h1F7F) return {6'b0, pa};                         // R7
        if (o[14:1] == 14'h1FFF) return {6'b0, pb};
        return 16'h0000;                                                    // R10
    endfunction

    function automatic string label(input logic f, input logic [1:0] m, input logic [14:0] o);
        if (f) return "R11";
        if (m == 2'd0) return "R3";
        if (m == 2'd2) return "R4";
        if (o[14]) return "R5";
        if ((o >= 15'h3E00 && o <= 15'h3E7F) || (o >= 15'h3F00 && o <= 15'h3F7F)) return "R6";
        if (o[14:1] == 14'h1F7F || o[14:1] == 14'h1FFF) return "R7";
        return "R10";
    endfunction

    task automatic set_bank(input logic [1:0] m);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = {4'hA, m, 2'b11};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_be = 2'b11;
    endtask

    task automatic rd_chk(input string req, input logic [19:0] a, input logic f,
                          input logic [15:0] exp);
        cpu_addr = a; cpu_fetch = f; cpu_rd = 1'b1;
        #1;
        chk(req, 32'(cpu_rdata), 32'(exp));
        cpu_rd = 1'b0; cpu_fetch = 1'b0;
    endtask

    task automatic sweep(input logic f, input logic [1:0] m);
        for (int o = 0; o < 32768; o += 2) begin
            cpu_addr = 20'hF8000 + 20'(o); cpu_fetch = f; cpu_rd = 1'b1;
            #1;
            chk(label(f, m, 15'(o)), 32'(cpu_rdata), 32'(model(cpu_addr, f, m, m_pa, m_pb)));
        end
        cpu_rd = 1'b0; cpu_fetch = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        wait (cyc == 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 R9: reset state of the fault outputs
        chk("R8", 32'(err_code), 32'h31);
        chk("R9", 32'(nmi), 32'h0);
        // R2: bank 0 after reset reads ROM
        rd_chk("R2", 20'hF8010, 1'b0, 16'h8010);
        // R1: below the window
        rd_chk("R1", 20'h00000, 1'b0, 16'h1234);
        rd_chk("R1", 20'h12346, 1'b0, 16'h2346 ^ 16'h1234);
        rd_chk("R1", 20'hF7FFE, 1'b0, 16'h7FFE ^ 16'h1234);
        // R12: selects in the request cycle
        cpu_addr = 20'h4000A; cpu_rd = 1'b1; #1;
        chk("R12", 32'({main_sel, rom_sel, ram_sel, vram_sel}), 32'b1000);
        chk("R1", 32'(main_addr), 32'h4000A);
        cpu_rd = 1'b0;

        // R7: page registers read 0 after reset, then load
        set_bank(2'd1);
        rd_chk("R7", 20'hFBEFE, 1'b0, 16'h0000);
        rd_chk("R7", 20'hFBFFE, 1'b0, 16'h0000);
        wr(20'hFBEFE, 16'hF2A5, 2'b01); m_pa = 10'h2A5;
        wr(20'hFBFFE, 16'hFFFF, 2'b11); m_pb = 10'h3FF;
        rd_chk("R7", 20'hFBEFE, 1'b0, 16'h02A5);
        rd_chk("R7", 20'hFBFFE, 1'b0, 16'h03FF);
        // R7: high lane only leaves the register alone
        wr(20'hFBEFE, 16'h0011, 2'b10);
        rd_chk("R7", 20'hFBEFE, 1'b0, 16'h02A5);
        // R6: aperture select and wrapped address
        cpu_addr = 20'hFBF05; cpu_rd = 1'b1; #1;
        chk("R6", 32'(vram_sel), 32'h1);
        chk("R6", 32'(vram_addr), 32'hFF85);
        cpu_rd = 1'b0;
        // R10: unmapped write has no effect and no interrupt
        wr(20'hF9000, 16'hFFFF, 2'b11);
        chk("R10", 32'(nmi), 32'h0);
        rd_chk("R10", 20'hF9000, 1'b0, 16'h0000);

        // R4: RAM write strobes while held
        set_bank(2'd2);
        @(negedge clk);
        cpu_addr = 20'hFC123; cpu_wdata = 16'hBEEF; cpu_be = 2'b10; cpu_wr = 1'b1; #1;
        chk("R4", 32'({ram_sel, mem_we, mem_be}), 32'b1110);
        chk("R4", 32'(ram_addr), 32'h4123);
        chk("R4", 32'(mem_wdata), 32'hBEEF);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_be = 2'b11;
        chk("R8", 32'(nmi), 32'h0);
        // R11: fetch in bank 2 gives main RAM, data read gives private RAM
        rd_chk("R11", 20'hF8200, 1'b1, 16'h8200 ^ 16'h1234);
        rd_chk("R4", 20'hF8200, 1'b0, 16'h0200 ^ 16'h5A5A);

        // R8: ROM write in bank 3 upper half
        set_bank(2'd3);
        wr(20'hFD000, 16'h1111, 2'b11);
        chk("R8", 32'(nmi), 32'h1);
        chk("R8", 32'(err_code), 32'hAE);
        // R9: acknowledge clears, code stays
        @(negedge clk); nmi_ack = 1'b1;
        @(negedge clk); nmi_ack = 1'b0;
        chk("R9", 32'(nmi), 32'h0);
        chk("R9", 32'(err_code), 32'hAE);
        // R9: ROM write beats acknowledge in the same cycle
        set_bank(2'd0);
        @(negedge clk);
        cpu_addr = 20'hF8004; cpu_wr = 1'b1; nmi_ack = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; nmi_ack = 1'b0;
        chk("R9", 32'(nmi), 32'h1);
        @(negedge clk); nmi_ack = 1'b1;
        @(negedge clk); nmi_ack = 1'b0;

        // Full sweeps: data reads per bank, then fetches per mode (R2 selects each)
        for (int b = 0; b < 4; b++) begin
            set_bank(2'(b));
            sweep(1'b0, 2'(b));
        end
        for (int b = 0; b < 4; b++) begin
            set_bank(2'(b));
            sweep(1'b1, 2'(b));
        end
        finish_run();
    end
endmodule